// File: doc/BRIEF.md
# Eight-Direction Compass Edge Detector

This block takes a raster stream of grayscale pixels, one per clock while the data-enable input is high, together with horizontal and vertical sync. It holds the two previous lines in line buffers and forms a 3x3 neighbourhood around each incoming pixel. Eight copies of one base kernel are evaluated on that neighbourhood, each turned by a further 45 degrees. The strongest response becomes the edge magnitude, and the number of the kernel that produced it becomes a 3-bit orientation code.

A two-bit family select chooses the base kernel. A threshold input turns the magnitude into a binary edge flag. The sync and enable inputs are delayed by the same number of stages as the pixel path, so the outputs can drive a downstream raster consumer directly.

A small fill state machine tracks how many lines of the current frame are already stored. It has three states. FILL_ROW0 means no line is stored yet. FILL_ROW1 means one line is stored. FILL_DONE means the window is full. A rising vertical sync returns the machine to FILL_ROW0 from any state, and so does reset. The end of a line, seen as the fall of data-enable, moves FILL_ROW0 to FILL_ROW1 and FILL_ROW1 to FILL_DONE. FILL_DONE stays where it is until the next frame starts.

Top module: `compass_edge_detector`

## Requirements
- R1: The neighbourhood ring is numbered clockwise as k=0 top-right, 1 right, 2 bottom-right, 3 bottom, 4 bottom-left, 5 left, 6 top-left, 7 top. Kernel d gives ring position k the base coefficient at ring index (k+d) mod 8. The family select picks the base ring and centre weight:
  - 0: ring 1,1,1,-1,-1,-1,1,1 with centre -2.
  - 1: ring 5,5,5,-3,-3,-3,-3,-3 with centre 0.
  - 2 and 3: ring 1,2,1,0,-1,-2,-1,0 with centre 0.
  So kernel 0 responds to a vertical edge that is brighter on the right, and higher indices turn anticlockwise in 45-degree steps.
- R2: The magnitude output is the largest of the eight responses after each negative response is clamped to zero, saturated to 255.
- R3: When the edge flag is high, the orientation output is the index of the largest response. If several responses are equal, the lowest index wins.
- R4: The edge flag is high exactly when the window is full and the saturated magnitude is strictly greater than the threshold input.
- R5: The orientation output is 0 whenever the edge flag is low.
- R6: A window is full only in state FILL_DONE, and only for a pixel at column 2 or later of its line. The window's bottom-right pixel is the current pixel. For any pixel whose window is not full, the magnitude, the flag and the orientation are 0.
- R7: Each pixel's results appear six clock cycles after the pixel is sampled. The vertical sync, horizontal sync and data-enable outputs are the inputs delayed by those same six cycles.
- R8: Pixel values presented while data-enable is low do not enter the line buffers or the window.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 8 | Grayscale pixel |
| de_i | input | 1 | Pixel valid (active video) |
| hs_i | input | 1 | Horizontal sync, delayed to hs_o |
| vs_i | input | 1 | Vertical sync; a rising edge starts a frame |
| family_i | input | 2 | Kernel family select (see R1) |
| thresh_i | input | 8 | Edge threshold |
| mag_o | output | 8 | Saturated edge magnitude |
| dir_o | output | 3 | Orientation code, 0 to 7 |
| edge_o | output | 1 | Binary edge flag |
| de_o | output | 1 | Delayed data-enable |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |

## Verification
The assertions assume a well-formed raster on the inputs, and the stimulus follows it:
- Every line of a frame has the same length and is no longer than the line buffer.
- At least one blanking cycle separates two lines.
- Vertical sync rises only while data-enable is low.
- The family and threshold inputs stay fixed from the start of a frame until its last result has left the pipeline.

The stimulus builds each frame under these rules. It inserts blanking between lines and flushes the pipeline between frames. It drives random garbage on the pixel input during every blanking cycle.

// File: rtl/cmp_edge_pkg.sv
package cmp_edge_pkg;

    localparam int N_DIR = 8;
    localparam int DIR_W = $clog2(N_DIR);

    typedef enum logic [1:0] {
        FAM_PREWITT  = 2'd0,
        FAM_KIRSCH   = 2'd1,
        FAM_ROBINSON = 2'd2,
        FAM_SOBEL    = 2'd3
    } fam_t;

    typedef enum logic [1:0] {
        FILL_ROW0 = 2'd0,
        FILL_ROW1 = 2'd1,
        FILL_DONE = 2'd2
    } fill_state_t;

    // Base ring coefficient at ring index k (k=0 top-right, clockwise).
    function automatic int ring_coef(fam_t fam, int k);
        unique case (fam)
            FAM_KIRSCH:  return (k < 3) ? 5 : -3;
            FAM_PREWITT: return (k >= 3 && k <= 5) ? -1 : 1;
            default: begin
                unique case (k)
                    0, 2:    return 1;
                    1:       return 2;
                    4, 6:    return -1;
                    5:       return -2;
                    default: return 0;
                endcase
            end
        endcase
    endfunction

    function automatic int centre_coef(fam_t fam);
        return (fam == FAM_PREWITT) ? -2 : 0;
    endfunction

endpackage

// File: rtl/cmp_edge_window.sv
module cmp_edge_window
    import cmp_edge_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PIX_W-1:0]             pix_i,
    input  logic                         de_i,
    input  logic                         vs_i,
    output logic [N_DIR-1:0][PIX_W-1:0]  ring_o,
    output logic [PIX_W-1:0]             centre_o,
    output logic                         ok_o
);

    localparam int COL_W = $clog2(LINE_W);

    fill_state_t       state_q, state_d;
    logic              vs_q, de_q;
    logic              vs_rise, line_end;
    logic [COL_W-1:0]  col_q;
    logic              win_ok_d;

    logic [PIX_W-1:0]  lb_near [LINE_W];
    logic [PIX_W-1:0]  lb_far  [LINE_W];
    logic [PIX_W-1:0]  up1, up2;

    logic [2:0][PIX_W-1:0] w_top, w_mid, w_bot;

    assign vs_rise  = vs_i & ~vs_q;
    assign line_end = de_q & ~de_i;

    // Next state of the fill machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_ROW0: if (vs_rise) state_d = FILL_ROW0;
                       else if (line_end) state_d = FILL_ROW1;
            FILL_ROW1: if (vs_rise) state_d = FILL_ROW0;
                       else if (line_end) state_d = FILL_DONE;
            FILL_DONE: if (vs_rise) state_d = FILL_ROW0;
            default:   state_d = FILL_ROW0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_ROW0;
            vs_q    <= 1'b0;
            de_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            vs_q    <= vs_i;
            de_q    <= de_i;
        end
    end

    // Outputs of the fill machine
    always_comb begin
        win_ok_d = de_i && (state_q == FILL_DONE) && (col_q >= COL_W'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (!de_i) begin
            col_q <= '0;
        end else if (col_q != COL_W'(LINE_W - 1)) begin
            col_q <= col_q + 1'b1;
        end
    end

    assign up1 = lb_near[col_q];
    assign up2 = lb_far[col_q];

    always_ff @(posedge clk) begin
        if (de_i) begin
            lb_near[col_q] <= pix_i;
            lb_far[col_q]  <= up1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_top <= '0;
            w_mid <= '0;
            w_bot <= '0;
            ok_o  <= 1'b0;
        end else begin
            ok_o <= win_ok_d;
            if (de_i) begin
                w_top <= {up2,   w_top[2], w_top[1]};
                w_mid <= {up1,   w_mid[2], w_mid[1]};
                w_bot <= {pix_i, w_bot[2], w_bot[1]};
            end
        end
    end

    // Ring positions, clockwise from top-right
    assign ring_o[0] = w_top[2];
    assign ring_o[1] = w_mid[2];
    assign ring_o[2] = w_bot[2];
    assign ring_o[3] = w_bot[1];
    assign ring_o[4] = w_bot[0];
    assign ring_o[5] = w_mid[0];
    assign ring_o[6] = w_top[0];
    assign ring_o[7] = w_top[1];
    assign centre_o  = w_mid[1];

endmodule

// File: rtl/cmp_edge_resp.sv
module cmp_edge_resp
    import cmp_edge_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int MAG_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  fam_t                         fam_i,
    input  logic [N_DIR-1:0][PIX_W-1:0]  ring_i,
    input  logic [PIX_W-1:0]             centre_i,
    input  logic                         ok_i,
    output logic [N_DIR-1:0][MAG_W-1:0]  resp_o,
    output logic                         ok_o
);

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        int               acc;
        logic [MAG_W-1:0] r_q;

        always_comb begin
            acc = centre_coef(fam_i) * int'(centre_i);
            for (int k = 0; k < N_DIR; k++) begin
                acc = acc + ring_coef(fam_i, (k + d) % N_DIR) * int'(ring_i[k]);
            end
        end

        // Negative responses clamp to zero
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= (acc < 0) ? '0 : MAG_W'(acc);
        end

        assign resp_o[d] = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_o <= 1'b0;
        else        ok_o <= ok_i;
    end

endmodule

// File: rtl/cmp_edge_maxtree.sv
module cmp_edge_maxtree #(
    parameter int VAL_W  = 12,
    parameter int N_LEAF = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LEAF-1:0][VAL_W-1:0]  leaf_i,
    input  logic                          ok_i,
    output logic [VAL_W-1:0]              max_o,
    output logic [$clog2(N_LEAF)-1:0]     idx_o,
    output logic                          ok_o
);

    localparam int LEVELS = $clog2(N_LEAF);
    localparam int IDX_W  = LEVELS;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int CNT = N_LEAF >> (l + 1);

        logic [2*CNT-1:0][VAL_W-1:0] v_in;
        logic [2*CNT-1:0][IDX_W-1:0] i_in;
        logic                        ok_in;
        logic [CNT-1:0][VAL_W-1:0]   v_q;
        logic [CNT-1:0][IDX_W-1:0]   i_q;
        logic                        ok_q;

        if (l == 0) begin : g_src
            assign v_in  = leaf_i;
            assign ok_in = ok_i;
            for (genvar j = 0; j < N_LEAF; j++) begin : g_leaf
                assign i_in[j] = IDX_W'(j);
            end
        end else begin : g_src
            assign v_in  = g_lvl[l-1].v_q;
            assign i_in  = g_lvl[l-1].i_q;
            assign ok_in = g_lvl[l-1].ok_q;
        end

        // Right operand wins only when strictly larger: lower index on ties
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q  <= '0;
                i_q  <= '0;
                ok_q <= 1'b0;
            end else begin
                ok_q <= ok_in;
                for (int i = 0; i < CNT; i++) begin
                    if (v_in[2*i+1] > v_in[2*i]) begin
                        v_q[i] <= v_in[2*i+1];
                        i_q[i] <= i_in[2*i+1];
                    end else begin
                        v_q[i] <= v_in[2*i];
                        i_q[i] <= i_in[2*i];
                    end
                end
            end
        end
    end

    assign max_o = g_lvl[LEVELS-1].v_q[0];
    assign idx_o = g_lvl[LEVELS-1].i_q[0];
    assign ok_o  = g_lvl[LEVELS-1].ok_q;

endmodule

// File: rtl/compass_edge_detector.sv
module compass_edge_detector
    import cmp_edge_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              de_i,
    input  logic              hs_i,
    input  logic              vs_i,
    input  logic [1:0]        family_i,
    input  logic [PIX_W-1:0]  thresh_i,
    output logic [PIX_W-1:0]  mag_o,
    output logic [DIR_W-1:0]  dir_o,
    output logic              edge_o,
    output logic              de_o,
    output logic              hs_o,
    output logic              vs_o
);

    localparam int MAG_W  = PIX_W + 4;
    localparam int LEVELS = $clog2(N_DIR);
    localparam int LAT    = 3 + LEVELS;

    logic [N_DIR-1:0][PIX_W-1:0] ring;
    logic [PIX_W-1:0]            centre;
    logic                        ok_win, ok_resp, ok_max;
    logic [N_DIR-1:0][MAG_W-1:0] resp;
    logic [MAG_W-1:0]            max_v;
    logic [DIR_W-1:0]            max_idx;
    logic [PIX_W-1:0]            sat_v;
    logic                        hit;
    logic [LAT-1:0][2:0]         sync_q;

    cmp_edge_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_i    (pix_i),
        .de_i     (de_i),
        .vs_i     (vs_i),
        .ring_o   (ring),
        .centre_o (centre),
        .ok_o     (ok_win)
    );

    cmp_edge_resp #(.PIX_W(PIX_W), .MAG_W(MAG_W)) resp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fam_i    (fam_t'(family_i)),
        .ring_i   (ring),
        .centre_i (centre),
        .ok_i     (ok_win),
        .resp_o   (resp),
        .ok_o     (ok_resp)
    );

    cmp_edge_maxtree #(.VAL_W(MAG_W), .N_LEAF(N_DIR)) tree_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .leaf_i (resp),
        .ok_i   (ok_resp),
        .max_o  (max_v),
        .idx_o  (max_idx),
        .ok_o   (ok_max)
    );

    assign sat_v = (|max_v[MAG_W-1:PIX_W]) ? '1 : max_v[PIX_W-1:0];
    assign hit   = ok_max && (sat_v > thresh_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag_o  <= '0;
            dir_o  <= '0;
            edge_o <= 1'b0;
        end else begin
            mag_o  <= ok_max ? sat_v : '0;
            dir_o  <= hit ? max_idx : '0;
            edge_o <= hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAT-2:0], {vs_i, hs_i, de_i}};
    end

    assign {vs_o, hs_o, de_o} = sync_q[LAT-1];

endmodule

// File: rtl/cmp_edge_checker.sv
module cmp_edge_checker #(
    parameter int PIX_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              de_i,
    input logic              hs_i,
    input logic              vs_i,
    input logic [PIX_W-1:0]  thresh_i,
    input logic [PIX_W-1:0]  mag_o,
    input logic [2:0]        dir_o,
    input logic              edge_o,
    input logic              de_o,
    input logic              hs_o,
    input logic              vs_o
);

    logic [2:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               age_q <= '0;
        else if (age_q != 3'd7)   age_q <= age_q + 3'd1;
    end

    // R5
    a_r5_dir_zero_without_edge: assert property (
        @(posedge clk) disable iff (!rst_n) !edge_o |-> dir_o == 3'd0);

    // R4
    a_r4_edge_above_thresh: assert property (
        @(posedge clk) disable iff (!rst_n) edge_o |-> mag_o > $past(thresh_i));

    // R6
    a_r6_quiet_in_blanking: assert property (
        @(posedge clk) disable iff (!rst_n) !de_o |-> (mag_o == '0 && !edge_o));

    // R7
    a_r7_sync_latency: assert property (
        @(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd6) |-> ({vs_o, hs_o, de_o} == $past({vs_i, hs_i, de_i}, 6)));

endmodule

bind compass_edge_detector cmp_edge_checker #(.PIX_W(PIX_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .de_i     (de_i),
    .hs_i     (hs_i),
    .vs_i     (vs_i),
    .thresh_i (thresh_i),
    .mag_o    (mag_o),
    .dir_o    (dir_o),
    .edge_o   (edge_o),
    .de_o     (de_o),
    .hs_o     (hs_o),
    .vs_o     (vs_o)
);

// File: tb/compass_edge_detector_tb.sv
module compass_edge_detector_tb_top;

    localparam int IMG_W = 8;
    localparam int IMG_H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_i = '0;
    logic       de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
    logic [1:0] family_i = '0;
    logic [7:0] thresh_i = '0;
    logic [7:0] mag_o;
    logic [2:0] dir_o;
    logic       edge_o, de_o, hs_o, vs_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int img [IMG_H][IMG_W];
    int cur_fam = 0;
    int cur_thr = 0;

    always #4 clk = ~clk;

    compass_edge_detector dut_i (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .de_i(de_i), .hs_i(hs_i),
        .vs_i(vs_i), .family_i(family_i), .thresh_i(thresh_i), .mag_o(mag_o),
        .dir_o(dir_o), .edge_o(edge_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Base ring coefficient, ring index 0 = top-right, clockwise (R1)
    function automatic int tb_coef(int fam, int k);
        int sob [8];
        sob = '{1, 2, 1, 0, -1, -2, -1, 0};
        if (fam == 1) return (k <= 2) ? 5 : -3;
        if (fam == 0) return (k == 3 || k == 4 || k == 5) ? -1 : 1;
        return sob[k];
    endfunction

    task automatic expect_pix(int r, int c, output int m, output int d, output int e);
        int dr [8];
        int dc [8];
        int best, bi, s;
        dr = '{2, 1, 0, 0, 0, 1, 2, 2};
        dc = '{0, 0, 0, 1, 2, 2, 2, 1};
        m = 0; d = 0; e = 0;
        if (r < 2 || c < 2) return;
        best = -1; bi = 0;
        for (int dd = 0; dd < 8; dd++) begin
            s = ((cur_fam == 0) ? -2 : 0) * img[r-1][c-1];
            for (int k = 0; k < 8; k++)
                s += tb_coef(cur_fam, (k + dd) % 8) * img[r-dr[k]][c-dc[k]];
            if (s < 0) s = 0;
            if (s > best) begin best = s; bi = dd; end
        end
        m = (best > 255) ? 255 : best;
        e = (m > cur_thr) ? 1 : 0;
        d = e ? bi : 0;
    endtask

    // Input history for the latency check (R7)
    logic [5:0][2:0] hist = '0;
    always @(posedge clk) hist <= {hist[4:0], {vs_i, hs_i, de_i}};

    int  orow = 0, ocol = 0;
    bit  vs_prev = 0, de_prev = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int em, ed, ee;
            check("R7 sync delay", {vs_o, hs_o, de_o}, hist[5]);
            if (vs_o && !vs_prev) begin orow = 0; ocol = 0; end
            if (de_o) begin
                expect_pix(orow, ocol, em, ed, ee);
                if (orow < 2 || ocol < 2) begin
                    check("R6 magnitude before window full", mag_o, 0);
                    check("R6 flag before window full", edge_o, 0);
                end else begin
                    // R8: blanking garbage must not disturb these values
                    check("R1 R2 R8 magnitude", mag_o, em);
                    check("R4 edge flag", edge_o, ee);
                end
                check("R3 R5 orientation", dir_o, ed);
                ocol++;
            end else if (de_prev) begin
                orow++; ocol = 0;
            end
            vs_prev = vs_o; de_prev = de_o;
        end
    end

    task automatic drive(bit de, bit hs, bit vs, int pix);
        @(negedge clk);
        de_i = de; hs_i = hs; vs_i = vs; pix_i = 8'(pix);
    endtask

    task automatic send_frame(int pat, int fam, int thr);
        for (int r = 0; r < IMG_H; r++)
            for (int c = 0; c < IMG_W; c++)
                case (pat)
                    0: img[r][c] = int'($urandom % 256);
                    1: img[r][c] = (c >= IMG_W / 2) ? 220 : 20;
                    2: img[r][c] = (r == 3 && c == 4) ? 200 : 0;
                    3: img[r][c] = (r * 30 + c * 17) % 256;
                    4: img[r][c] = 77;
                    default: img[r][c] = (r >= 3) ? 250 : 10;
                endcase
        @(negedge clk);
        cur_fam = fam; cur_thr = thr;
        family_i = 2'(fam); thresh_i = 8'(thr);
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        for (int r = 0; r < IMG_H; r++) begin
            drive(0, 1, 0, int'($urandom % 256));
            drive(0, 0, 0, int'($urandom % 256));
            for (int c = 0; c < IMG_W; c++) drive(1, 0, 0, img[r][c]);
        end
        for (int i = 0; i < 12; i++) drive(0, 0, 0, int'($urandom % 256));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 reset magnitude", mag_o, 0);
        check("R9 reset orientation", dir_o, 0);
        check("R9 reset flag", edge_o, 0);
        check("R9 reset syncs", {vs_o, hs_o, de_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int fam = 0; fam < 4; fam++)
            for (int pat = 0; pat < 6; pat++)
                send_frame(pat, fam, (pat * 41 + fam * 23 + 10) % 200);
        // Threshold extremes on a random frame
        send_frame(0, 1, 0);
        send_frame(0, 3, 255);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule